// File: doc/BRIEF.md
# Transmit DMA Channel Control and Status Registers

This block holds the software-visible control and status state for a bank of transmit DMA channels. Each channel has a configuration register carrying a run mode and a request-enable bit. Each channel also keeps a credit counter. An activate command loads the counter, and each transferred dword counts it down. While the counter is nonzero the channel holds a pending request. The datapath itself sits elsewhere and only reports events to this block as single-cycle pulses.

A shared status word shows, for each channel, whether its buffers are drained and whether it is fully idle. Software polls it after stopping a channel. A shared error word collects fault events as sticky flags that software clears by writing ones. Two flags are global: an internal address fault and a dword-count mismatch from the host. Two groups are per channel. One marks an activate that arrives while a request is still pending. The other marks a FIFO-full indication that arrives while the credit counter is nonzero.

Registers are written through a single-cycle write strobe and read through a combinational read port.

Top module: `txdma_ctl_status`

## Requirements
- R1: Channel n's configuration register sits at address n*0x20. Only bits 31:30 (mode) and bit 3 (request enable) are stored. All other bits read as 0, and the register resets to 0.
- R2: An activate pulse loads the channel's credit counter from `act_credit` only when three conditions hold: the mode is 10 (normal), bit 3 is 1, and the counter is 0. In every other case the pulse leaves the counter unchanged.
- R3: A dword pulse decrements a nonzero credit counter when the mode is 10 (normal) or 01 (pause at end of frame). In modes 00 and 11 the counter holds.
- R4: The status word at 0x100 places channel n's flags as follows. Bit 24+n is 1 when the credit counter is 0. Bit 16+n is 1 when the counter is 0 and the mode is 00 or 11. All other bits read 0, so the word reads 0xFFFF0000 after reset.
- R5: An activate pulse on channel n while its credit counter is nonzero sets error bit 9+n.
- R6: A FIFO-full pulse on channel n while its credit counter is nonzero sets error bit n. With a zero counter the pulse sets nothing.
- R7: An address-fault pulse sets error bit 31, and a dword-mismatch pulse sets error bit 30.
- R8: The error word sits at 0x104. Its bits stay set until a write to 0x104 carries a 1 in that bit position. Written 0s leave bits unchanged, and undefined bits read 0.
- R9: When a set event and a write-one clear hit the same error bit in the same cycle, the bit ends up set.
- R10: Addresses with no register read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 9 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 9 | Read byte address |
| rd_data | output | 32 | Read data (combinational) |
| act_pulse | input | 8 | Per-channel activate command |
| act_credit | input | 12 | Credit value loaded on an accepted activate |
| dword_pulse | input | 8 | Per-channel dword transferred |
| fifo_full | input | 8 | Per-channel FIFO-full indication |
| addr_fault | input | 1 | Internal memory address fault |
| dword_mismatch | input | 1 | Host dword count mismatch |

## Verification
The assertions check three things on every cycle. A nonzero credit counter only holds or drops by one. A zero counter stays zero unless an activate is accepted. A counter in a halted mode stays frozen. They also check that no error flag drops without a write-one and that every set event leaves its flag high. The idle flags in the status word must always imply the matching empty flags. What only the scenarios can show is the effect of ordering over several cycles. One example is the credit surviving a refused second activate and then draining after exactly the first load's count of dwords. Others are a pause at end of frame draining and then refusing new work, and the exact bit positions that software sees at the read port.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

   typedef enum logic [1:0] {
      CH_HALT  = 2'b00,
      CH_DRAIN = 2'b01,
      CH_RUN   = 2'b10,
      CH_RSVD  = 2'b11
   } ch_mode_e;

   localparam int CFG_STRIDE   = 32'h20;
   localparam int STATUS_OFS   = 32'h100;
   localparam int ERR_OFS      = 32'h104;
   localparam int BUSY_ERR_LSB = 9;
   localparam int CRED_ERR_LSB = 0;
   localparam int ADDR_ERR_BIT = 31;
   localparam int CNT_ERR_BIT  = 30;

   // modes in which an accepted transfer keeps moving
   function automatic logic mode_moves(ch_mode_e m);
      return (m == CH_RUN) || (m == CH_DRAIN);
   endfunction

   function automatic logic [31:0] err_mask(int n_ch);
      logic [31:0] m;
      m = '0;
      m[ADDR_ERR_BIT] = 1'b1;
      m[CNT_ERR_BIT]  = 1'b1;
      for (int i = 0; i < n_ch; i++) begin
         m[CRED_ERR_LSB + i] = 1'b1;
         m[BUSY_ERR_LSB + i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/txdma_chan.sv
module txdma_chan
   import txdma_pkg::*;
#(
   parameter int CREDIT_W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [31:0]         cfg_wdata,
   input  logic                act_i,
   input  logic [CREDIT_W-1:0] act_credit_i,
   input  logic                dword_i,
   input  logic                fifo_full_i,
   output logic [31:0]         cfg_rdata,
   output logic                empty_o,
   output logic                idle_o,
   output logic                busy_err_o,
   output logic                credit_err_o
);

   ch_mode_e            mode_q;
   logic                dreq_en_q;
   logic [CREDIT_W-1:0] cred_q;
   logic                pending;
   logic                accept;
   logic                drain_step;

   assign pending    = (cred_q != '0);
   assign accept     = act_i && (mode_q == CH_RUN) && dreq_en_q && !pending;
   assign drain_step = dword_i && pending && mode_moves(mode_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q    <= CH_HALT;
         dreq_en_q <= 1'b0;
         cred_q    <= '0;
      end else begin
         if (cfg_we) begin
            mode_q    <= ch_mode_e'(cfg_wdata[31:30]);
            dreq_en_q <= cfg_wdata[3];
         end
         if (accept)
            cred_q <= act_credit_i;
         else if (drain_step)
            cred_q <= cred_q - CREDIT_W'(1);
      end
   end

   assign cfg_rdata    = {mode_q, 26'b0, dreq_en_q, 3'b0};
   assign empty_o      = !pending;
   assign idle_o       = !pending && !mode_moves(mode_q);
   assign busy_err_o   = act_i && pending;
   assign credit_err_o = fifo_full_i && pending;

   // R3
   credit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cred_q != '0) |=> (cred_q == $past(cred_q)) ||
                         (cred_q == $past(cred_q) - CREDIT_W'(1)));

   // R3
   halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cred_q != '0) && (mode_q == CH_HALT || mode_q == CH_RSVD)) |=> $stable(cred_q));

   // R2
   no_spurious_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cred_q == '0) && !(act_i && mode_q == CH_RUN && dreq_en_q)) |=> (cred_q == '0));

endmodule

// File: rtl/txdma_err_reg.sv
module txdma_err_reg #(
   parameter int          WIDTH = 32,
   parameter logic [31:0] MASK  = 32'hFFFF_FFFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic             clr_we,
   input  logic [WIDTH-1:0] clr_data,
   output logic [WIDTH-1:0] err_o
);

   localparam logic [WIDTH-1:0] KEEP = MASK[WIDTH-1:0];

   logic [WIDTH-1:0] err_q;
   logic [WIDTH-1:0] clr_vec;

   assign clr_vec = clr_we ? clr_data : '0;

   always_ff @(posedge clk) begin
      if (!rst_n)
         err_q <= '0;
      else
         err_q <= ((err_q & ~clr_vec) | set_i) & KEEP;
   end

   assign err_o = err_q;

   // R8
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((err_q & $past(err_q & ~clr_vec)) == $past(err_q & ~clr_vec)));

   // R9
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_i & KEEP) != '0) |=> ((err_q & $past(set_i & KEEP)) == $past(set_i & KEEP)));

endmodule

// File: rtl/txdma_ctl_status.sv
module txdma_ctl_status
   import txdma_pkg::*;
#(
   parameter int N_CH     = 8,
   parameter int CREDIT_W = 12,
   parameter int ADDR_W   = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [31:0]         wr_data,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [31:0]         rd_data,
   input  logic [N_CH-1:0]     act_pulse,
   input  logic [CREDIT_W-1:0] act_credit,
   input  logic [N_CH-1:0]     dword_pulse,
   input  logic [N_CH-1:0]     fifo_full,
   input  logic                addr_fault,
   input  logic                dword_mismatch
);

   localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(STATUS_OFS);
   localparam logic [ADDR_W-1:0] ERR_ADDR    = ADDR_W'(ERR_OFS);
   localparam logic [31:0]       ERR_KEEP    = err_mask(N_CH);

   if (N_CH < 1 || N_CH > 8) begin : g_bad_nch
      $error("N_CH must lie in 1..8 to fit the shared status and error layout");
   end
   if (N_CH * CFG_STRIDE > STATUS_OFS) begin : g_bad_map
      $error("channel configuration window overlaps the shared registers");
   end
   if ((1 << ADDR_W) <= ERR_OFS) begin : g_bad_aw
      $error("ADDR_W too narrow for the register map");
   end
   if (CREDIT_W < 1 || CREDIT_W > 31) begin : g_bad_cw
      $error("CREDIT_W out of range");
   end

   logic [31:0]     cfg_rd [N_CH];
   logic [N_CH-1:0] ch_empty;
   logic [N_CH-1:0] ch_idle;
   logic [N_CH-1:0] ch_busy_err;
   logic [N_CH-1:0] ch_cred_err;
   logic [31:0]     status_w;
   logic [31:0]     err_set;
   logic [31:0]     err_w;
   logic            err_clr_we;

   for (genvar n = 0; n < N_CH; n++) begin : g_ch
      localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_W'(n * CFG_STRIDE);
      logic cfg_we;
      assign cfg_we = wr_en && (wr_addr == CH_ADDR);

      txdma_chan #(.CREDIT_W(CREDIT_W)) i_chan (
         .clk          (clk),
         .rst_n        (rst_n),
         .cfg_we       (cfg_we),
         .cfg_wdata    (wr_data),
         .act_i        (act_pulse[n]),
         .act_credit_i (act_credit),
         .dword_i      (dword_pulse[n]),
         .fifo_full_i  (fifo_full[n]),
         .cfg_rdata    (cfg_rd[n]),
         .empty_o      (ch_empty[n]),
         .idle_o       (ch_idle[n]),
         .busy_err_o   (ch_busy_err[n]),
         .credit_err_o (ch_cred_err[n])
      );
   end

   always_comb begin
      status_w = '0;
      for (int i = 0; i < N_CH; i++) begin
         status_w[24 + i] = ch_empty[i];
         status_w[16 + i] = ch_idle[i];
      end
   end

   always_comb begin
      err_set = '0;
      err_set[ADDR_ERR_BIT] = addr_fault;
      err_set[CNT_ERR_BIT]  = dword_mismatch;
      for (int i = 0; i < N_CH; i++) begin
         err_set[BUSY_ERR_LSB + i] = ch_busy_err[i];
         err_set[CRED_ERR_LSB + i] = ch_cred_err[i];
      end
   end

   assign err_clr_we = wr_en && (wr_addr == ERR_ADDR);

   txdma_err_reg #(.WIDTH(32), .MASK(ERR_KEEP)) i_err (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (err_set),
      .clr_we   (err_clr_we),
      .clr_data (wr_data),
      .err_o    (err_w)
   );

   always_comb begin
      rd_data = '0;
      if (rd_addr == STATUS_ADDR)
         rd_data = status_w;
      else if (rd_addr == ERR_ADDR)
         rd_data = err_w;
      else
         for (int i = 0; i < N_CH; i++)
            if (rd_addr == ADDR_W'(i * CFG_STRIDE))
               rd_data = cfg_rd[i];
   end

   // R4
   idle_implies_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_w[23:16] & ~status_w[31:24]) == 8'h00));

   // R6
   cred_err_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_full[0] && !ch_empty[0]) |=> err_w[CRED_ERR_LSB]);

endmodule

// File: tb/test_txdma_ctl_status.sv
module test_txdma_ctl_status;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [8:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [8:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [7:0]  act_pulse = '0;
   logic [11:0] act_credit = '0;
   logic [7:0]  dword_pulse = '0;
   logic [7:0]  fifo_full = '0;
   logic        addr_fault = 1'b0;
   logic        dword_mismatch = 1'b0;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   txdma_ctl_status i_txdma_ctl_status (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .act_pulse(act_pulse), .act_credit(act_credit),
      .dword_pulse(dword_pulse), .fifo_full(fifo_full), .addr_fault(addr_fault),
      .dword_mismatch(dword_mismatch)
   );

   // behavioural reference model
   int          m_mode [8];
   bit          m_en   [8];
   int          m_cred [8];
   logic [31:0] m_err;

   always @(posedge clk) begin
      logic [31:0] setv;
      logic [31:0] clrv;
      if (!rst_n) begin
         for (int c = 0; c < 8; c++) begin
            m_mode[c] = 0; m_en[c] = 0; m_cred[c] = 0;
         end
         m_err = '0;
      end else begin
         setv = '0;
         for (int c = 0; c < 8; c++) begin
            if (act_pulse[c] && m_cred[c] != 0) setv[9 + c] = 1'b1;
            if (fifo_full[c] && m_cred[c] != 0) setv[c] = 1'b1;
            if (act_pulse[c] && m_cred[c] == 0 && m_mode[c] == 2 && m_en[c])
               m_cred[c] = int'(act_credit);
            else if (dword_pulse[c] && m_cred[c] != 0 && (m_mode[c] == 1 || m_mode[c] == 2))
               m_cred[c] = m_cred[c] - 1;
            if (wr_en && int'(wr_addr) == c * 32) begin
               m_mode[c] = int'(wr_data[31:30]);
               m_en[c]   = wr_data[3];
            end
         end
         setv[31] = addr_fault;
         setv[30] = dword_mismatch;
         clrv = (wr_en && wr_addr == 9'h104) ? wr_data : 32'h0;
         m_err = (m_err & ~clrv) | setv;
      end
   end

   function automatic logic [31:0] m_read(logic [8:0] a);
      logic [31:0] v;
      v = '0;
      if (a < 9'h100 && a[4:0] == 5'd0) begin
         v[31:30] = 2'(m_mode[a[7:5]]);
         v[3]     = m_en[a[7:5]];
      end else if (a == 9'h100) begin
         for (int c = 0; c < 8; c++) begin
            v[24 + c] = (m_cred[c] == 0);
            v[16 + c] = (m_cred[c] == 0) && !(m_mode[c] == 1 || m_mode[c] == 2);
         end
      end else if (a == 9'h104) begin
         v = m_err;
      end
      return v;
   endfunction

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [31:0] e;
         e = m_read(rd_addr);
         n_cmp++;
         if (rd_data !== e) begin
            n_bad++;
            $display("FAIL model %s addr=%h actual=%h expected=%h",
                     (rd_addr == 9'h100) ? "R4" : (rd_addr == 9'h104) ? "R8" :
                     (rd_addr < 9'h100 && rd_addr[4:0] == 0) ? "R1" : "R10",
                     rd_addr, rd_data, e);
         end
      end
   end

   task automatic step();
      @(posedge clk); #2;
   endtask

   task automatic wr(input logic [8:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic act(input int c, input logic [11:0] cr);
      act_pulse[c] = 1'b1; act_credit = cr;
      step();
      act_pulse = '0;
   endtask

   task automatic dw(input int c);
      dword_pulse[c] = 1'b1;
      step();
      dword_pulse = '0;
   endtask

   task automatic chk(input logic [8:0] a, input logic [31:0] exp, input string tag);
      rd_addr = a;
      @(negedge clk);
      n_cmp++;
      if (rd_data !== exp) begin
         n_bad++;
         $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rd_data, exp);
      end
      step();
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         done = 1;
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R4 reset state, R1 reset config, R8 reset errors
      chk(9'h100, 32'hFFFF_0000, "R4 reset status");
      chk(9'h000, 32'h0, "R1 reset config");
      chk(9'h104, 32'h0, "R8 reset error");
      // R1 stored fields only
      wr(9'h000, 32'h8000_0008);
      chk(9'h000, 32'h8000_0008, "R1 cfg0 normal");
      wr(9'h020, 32'hFFFF_FFFF);
      chk(9'h020, 32'hC000_0008, "R1 reserved bits read 0");
      // R2 accepted activate
      act(0, 12'd3);
      chk(9'h100, 32'hFEFE_0000, "R2 activate loads credit");
      // R2 mode 11 ignores activate
      act(1, 12'd5);
      chk(9'h100, 32'hFEFE_0000, "R2 activate ignored in mode 11");
      // R5 activate while pending
      act(0, 12'd7);
      chk(9'h104, 32'h0000_0200, "R5 busy error bit 9");
      // R6 fifo full with and without credit
      fifo_full = 8'h05;
      step();
      fifo_full = '0;
      chk(9'h104, 32'h0000_0201, "R6 credit error only on ch0");
      // R3 drain of the original 3 credits
      dw(0); dw(0);
      chk(9'h100, 32'hFEFE_0000, "R3 two dwords still pending");
      dw(0);
      chk(9'h100, 32'hFFFE_0000, "R3 third dword empties");
      // R3 pause at end of frame keeps draining
      wr(9'h060, 32'h8000_0008);
      act(3, 12'd2);
      wr(9'h060, 32'h4000_0000);
      dw(3); dw(3);
      chk(9'h100, 32'hFFF6_0000, "R3 drain mode finishes");
      act(3, 12'd1);
      chk(9'h100, 32'hFFF6_0000, "R2 drain mode refuses activate");
      // R3 halt freezes credit
      wr(9'h060, 32'h8000_0008);
      act(3, 12'd2);
      wr(9'h060, 32'h0);
      dw(3); dw(3);
      chk(9'h100, 32'hF7F6_0000, "R3 halt freezes credit");
      // R7 global errors
      addr_fault = 1'b1; dword_mismatch = 1'b1;
      step();
      addr_fault = 1'b0; dword_mismatch = 1'b0;
      chk(9'h104, 32'hC000_0201, "R7 global error bits");
      // R8 write-one clear and write-zero no effect
      wr(9'h104, 32'h8000_0001);
      chk(9'h104, 32'h4000_0200, "R8 write one clears");
      wr(9'h104, 32'h0);
      chk(9'h104, 32'h4000_0200, "R8 write zero keeps");
      // R9 set wins over clear
      dword_mismatch = 1'b1;
      wr(9'h104, 32'h4000_0000);
      dword_mismatch = 1'b0;
      chk(9'h104, 32'h4000_0200, "R9 set beats clear");
      // R10 unmapped
      wr(9'h010, 32'hFFFF_FFFF);
      chk(9'h010, 32'h0, "R10 unmapped reads zero");
      chk(9'h108, 32'h0, "R10 beyond error word");
      chk(9'h000, 32'h8000_0008, "R10 unmapped write leaves cfg0");
      repeat (4) step();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule